// File: doc/BRIEF.md
# Timekeeper SPI Register Port

This block is the serial front end of a real-time clock. A host reaches the clock's sixteen byte-wide registers over a four-wire SPI link. The register file and the timekeeping counters sit behind a simple parallel port with a write strobe, a read strobe and a four-bit address. The block runs entirely on the system clock. SCLK, CS and MOSI pass through two-flop synchronisers, and SCLK transitions are found by edge detection. This means SCLK must be well below the system clock rate.

Each transaction opens when CS goes high. The first byte is a command. Its high bit chooses between read and write. Its bit 4 is a fixed marker that has to be set. Its low nibble names the first register. Every later complete byte is either written into the register file or shifted out of it, and the register address advances after each one. A command without the marker makes the rest of the transaction inert. Releasing CS ends the transaction and throws away any partly received byte.

Top module: `rtc_spi_regport`

## Requirements
- R1: CS is active high. While the synchronised CS is low, SCLK and MOSI have no effect, neither register strobe fires, and MISO is 0.
- R2: A command with bit 4 = 1 and bit 7 = 0 is a write. Bits 6:5 are don't-care and bits 3:0 give the start address. Each following complete byte appears once on `reg_wr_data` with one `reg_wr_en` pulse at the current address.
- R3: A command with bit 7 = 1 and bit 4 = 1 is a read starting at the address in bits 3:0. Each following byte slot shifts that register's value out on MISO, MSB first.
- R4: After each data byte the register address advances by one, and it wraps from 0xF to 0x0.
- R5: A command with bit 4 = 0 is ignored for the rest of the transaction. There are no writes and no reads, and MISO stays 0 until CS drops.
- R6: The link is SPI mode 0. MOSI is captured on rising SCLK and MISO changes only after falling SCLK. With SCLK half periods of at least 8 system clocks, each MISO bit is stable before the rising edge that the host samples it on.
- R7: A byte that is incomplete when CS is released causes no register access.
- R8: `reg_wr_en` and `reg_rd_en` are never high in the same cycle.
- R9: After reset, MISO is 0 and both register strobes are low.
- R10: A seven-byte read burst from address 0x02 returns registers 0x02 through 0x08 in ascending order.
- R11: When an SCLK rising edge and the release of CS reach the synchronisers in the same cycle, that edge is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from the host |
| spi_cs | input | 1 | Chip select, active high |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| reg_addr | output | ADDR_W | Register address for either strobe |
| reg_wr_en | output | 1 | Register write strobe |
| reg_wr_data | output | DATA_W | Register write data |
| reg_rd_en | output | 1 | Register read strobe; data is expected the next cycle |
| reg_rd_data | input | DATA_W | Register read data, registered by the register file |

## Verification
The case that needs care is a byte boundary that coincides with the end of the transaction. The eighth rising SCLK edge of a byte and the release of CS can reach the synchronisers in the same system clock cycle. The bench provokes this by changing CS and SCLK at the same instant after seven bits of a write data byte. It then reads the target register back through a fresh read burst and expects its old value. A scoreboard flags any write strobe that appears without a queued expectation. A companion case releases CS in the middle of a byte after one full byte has been written. There, exactly the one complete byte must reach the register port.

// File: rtl/rtc_spi_pkg.sv
package rtc_spi_pkg;
  localparam int unsigned DATA_W       = 8;
  localparam int unsigned ADDR_W       = 4;
  localparam int unsigned CMD_RD_BIT   = 7;
  localparam int unsigned CMD_MARK_BIT = 4;
  localparam int unsigned SYNC_STAGES  = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_WR,
    ST_RD,
    ST_IGN
  } xfer_state_e;
endpackage

// File: rtl/rtc_spi_sync.sv
module rtc_spi_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] q_out
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] pipe_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe_q <= '0;
      else        pipe_q <= {pipe_q[STAGES-2:0], d_in[g]};
    end
    assign q_out[g] = pipe_q[STAGES-1];
  end
endmodule

// File: rtl/rtc_spi_shifter.sv
module rtc_spi_shifter #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              sclk_rise,
  input  logic              sclk_fall,
  input  logic              mosi_bit,
  input  logic              load_en,
  input  logic [DATA_W-1:0] load_data,
  output logic [DATA_W-1:0] rx_byte,
  output logic              byte_done,
  output logic              miso
);
  localparam int unsigned CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] rx_q, rx_d;
  logic [DATA_W-1:0] tx_q, tx_d;

  always_comb begin
    cnt_d     = cnt_q;
    rx_d      = rx_q;
    tx_d      = tx_q;
    rx_byte   = {rx_q[DATA_W-2:0], mosi_bit};
    byte_done = sel && sclk_rise && (cnt_q == LAST);
    if (!sel) begin
      cnt_d = '0;
      tx_d  = '0;
    end else begin
      if (sclk_rise) begin
        rx_d  = rx_byte;
        cnt_d = (cnt_q == LAST) ? '0 : cnt_q + CNT_W'(1);
      end
      if (load_en)
        tx_d = load_data;
      else if (sclk_fall && (cnt_q != '0))
        tx_d = {tx_q[DATA_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rx_q  <= '0;
      tx_q  <= '0;
    end else begin
      cnt_q <= cnt_d;
      rx_q  <= rx_d;
      tx_q  <= tx_d;
    end
  end

  assign miso = tx_q[DATA_W-1];

  p_tx_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !sclk_fall && !load_en) |=> $stable(miso))
    else $error("MISO moved without a falling SCLK edge or a load");
endmodule

// File: rtl/rtc_spi_ctrl.sv
module rtc_spi_ctrl
  import rtc_spi_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              byte_done,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] reg_addr,
  output logic              reg_wr_en,
  output logic [DATA_W-1:0] reg_wr_data,
  output logic              reg_rd_en,
  output logic              load_en,
  output logic [DATA_W-1:0] load_data
);
  xfer_state_e       state_q, state_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic              wr_q, wr_d;
  logic [DATA_W-1:0] wdata_q, wdata_d;
  logic              fetch_q, fetch_d;
  logic              load_q, load_d;
  logic              unused_cmd_bits;

  assign unused_cmd_bits = &{1'b0, rx_byte};

  always_comb begin
    state_d = state_q;
    ptr_d   = ptr_q;
    wr_d    = 1'b0;
    wdata_d = wdata_q;
    fetch_d = 1'b0;
    load_d  = fetch_q;
    if (wr_q || load_q) ptr_d = ptr_q + ADDR_W'(1);
    case (state_q)
      ST_IDLE: state_d = ST_CMD;
      ST_CMD: if (byte_done) begin
        ptr_d = rx_byte[ADDR_W-1:0];
        if (!rx_byte[CMD_MARK_BIT]) state_d = ST_IGN;
        else if (rx_byte[CMD_RD_BIT]) begin
          state_d = ST_RD;
          fetch_d = 1'b1;
        end else state_d = ST_WR;
      end
      ST_WR: if (byte_done) begin
        wr_d    = 1'b1;
        wdata_d = rx_byte;
      end
      ST_RD: if (byte_done) fetch_d = 1'b1;
      default: ;
    endcase
    if (!sel) begin
      state_d = ST_IDLE;
      fetch_d = 1'b0;
      load_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ptr_q   <= '0;
      wr_q    <= 1'b0;
      wdata_q <= '0;
      fetch_q <= 1'b0;
      load_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      ptr_q   <= ptr_d;
      wr_q    <= wr_d;
      wdata_q <= wdata_d;
      fetch_q <= fetch_d;
      load_q  <= load_d;
    end
  end

  assign reg_addr    = ptr_q;
  assign reg_wr_en   = wr_q;
  assign reg_wr_data = wdata_q;
  assign reg_rd_en   = fetch_q;
  assign load_en     = load_q;
  assign load_data   = rd_data;

  p_quiet_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> (!reg_wr_en && !reg_rd_en))
    else $error("register strobe while deselected");

  p_ignore_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IGN) |-> (!reg_wr_en && !reg_rd_en && !load_en))
    else $error("register access after unmarked command");

  p_port_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr_en && reg_rd_en))
    else $error("write and read strobes together");

  p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |=> (reg_addr == ADDR_W'($past(reg_addr) + ADDR_W'(1))))
    else $error("address did not advance after a write");
endmodule

// File: rtl/rtc_spi_regport.sv
module rtc_spi_regport
  import rtc_spi_pkg::*;
#(
  parameter int unsigned DW = DATA_W,
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned NSYNC = SYNC_STAGES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          spi_sclk,
  input  logic          spi_cs,
  input  logic          spi_mosi,
  output logic          spi_miso,
  output logic [AW-1:0] reg_addr,
  output logic          reg_wr_en,
  output logic [DW-1:0] reg_wr_data,
  output logic          reg_rd_en,
  input  logic [DW-1:0] reg_rd_data
);
  logic [1:0]    rst_pipe_q;
  logic          rst_n_int;
  logic [2:0]    pins_s;
  logic          sclk_s, cs_s, mosi_s;
  logic          sclk_d_q;
  logic          sclk_rise, sclk_fall;
  logic [DW-1:0] rx_byte;
  logic          byte_done;
  logic          load_en;
  logic [DW-1:0] load_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_int = rst_pipe_q[1];

  rtc_spi_sync #(.WIDTH(3), .STAGES(NSYNC)) u_sync (
    .clk   (clk),
    .rst_n (rst_n_int),
    .d_in  ({spi_sclk, spi_cs, spi_mosi}),
    .q_out (pins_s)
  );
  assign {sclk_s, cs_s, mosi_s} = pins_s;

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) sclk_d_q <= 1'b0;
    else            sclk_d_q <= sclk_s;
  end
  assign sclk_rise = sclk_s && !sclk_d_q;
  assign sclk_fall = !sclk_s && sclk_d_q;

  rtc_spi_shifter #(.DATA_W(DW)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .sel       (cs_s),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .mosi_bit  (mosi_s),
    .load_en   (load_en),
    .load_data (load_data),
    .rx_byte   (rx_byte),
    .byte_done (byte_done),
    .miso      (spi_miso)
  );

  rtc_spi_ctrl #(.DATA_W(DW), .ADDR_W(AW)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .sel         (cs_s),
    .byte_done   (byte_done),
    .rx_byte     (rx_byte),
    .rd_data     (reg_rd_data),
    .reg_addr    (reg_addr),
    .reg_wr_en   (reg_wr_en),
    .reg_wr_data (reg_wr_data),
    .reg_rd_en   (reg_rd_en),
    .load_en     (load_en),
    .load_data   (load_data)
  );

  p_miso_low_unsel_r1: assert property (@(posedge clk) disable iff (!rst_n_int)
    !cs_s |=> !spi_miso)
    else $error("MISO high while deselected");
endmodule

// File: tb/rtc_spi_regport_test.sv
module rtc_spi_regport_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       spi_sclk, spi_cs, spi_mosi, spi_miso;
  logic [3:0] reg_addr;
  logic       reg_wr_en, reg_rd_en;
  logic [7:0] reg_wr_data, reg_rd_data;

  logic [7:0]  mem [16];
  logic [7:0]  ref_mem [16];
  logic [11:0] exp_q [$];
  int checks = 0;
  int fails = 0;
  int rd_events = 0;
  int overlap_seen = 0;
  bit done = 0;
  string cur_req = "R2";

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_spi_regport uut (
    .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs(spi_cs),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso), .reg_addr(reg_addr),
    .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
    .reg_rd_en(reg_rd_en), .reg_rd_data(reg_rd_data)
  );

  always @(posedge clk) begin
    if (reg_wr_en) mem[reg_addr] <= reg_wr_data;
    if (reg_rd_en) reg_rd_data <= mem[reg_addr];
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: every write strobe must match a queued expectation
  always @(negedge clk) begin
    if (rst_n) begin
      if (reg_wr_en && reg_rd_en) overlap_seen++;
      if (reg_rd_en) rd_events++;
      if (reg_wr_en) begin
        if (exp_q.size() == 0)
          check(0, cur_req, {reg_addr, reg_wr_data}, 0);
        else begin
          logic [11:0] e;
          e = exp_q.pop_front();
          check({reg_addr, reg_wr_data} == e, cur_req, {reg_addr, reg_wr_data}, e);
        end
      end
    end
  end

  task automatic xfer_bits(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - nbits; i--) begin
      spi_mosi = tx[i];
      repeat (HALF) @(negedge clk);
      rx[i] = spi_miso;
      spi_sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      spi_sclk = 1'b0;
    end
  endtask

  task automatic open_xfer();
    spi_cs = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic close_xfer();
    repeat (HALF) @(negedge clk);
    spi_cs = 1'b0;
    repeat (4*HALF) @(negedge clk);
  endtask

  task automatic write_burst(input logic [3:0] a, input int n, input logic [7:0] seed, input string req);
    logic [7:0] rx, d;
    logic [3:0] p;
    cur_req = req;
    open_xfer();
    xfer_bits(8'h10 | {4'h0, a}, 8, rx);
    for (int k = 0; k < n; k++) begin
      d = seed + 8'(k * 37);
      p = a + 4'(k);
      exp_q.push_back({p, d});
      ref_mem[p] = d;
      xfer_bits(d, 8, rx);
    end
    close_xfer();
  endtask

  task automatic read_burst(input logic [3:0] a, input int n, input string req);
    logic [7:0] rx;
    logic [3:0] p;
    open_xfer();
    xfer_bits(8'h90 | {4'h0, a}, 8, rx);
    for (int k = 0; k < n; k++) begin
      p = a + 4'(k);
      xfer_bits(8'h00, 8, rx);
      check(rx == ref_mem[p], req, rx, ref_mem[p]);
    end
    close_xfer();
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [7:0] rx;
    int rd_before;
    for (int i = 0; i < 16; i++) begin
      mem[i] = 8'h31 + 8'(i * 11);
      ref_mem[i] = mem[i];
    end
    reg_rd_data = '0;
    spi_sclk = 0; spi_cs = 0; spi_mosi = 0;
    rst_n = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);

    // R9 reset state
    check(spi_miso == 0, "R9 miso", spi_miso, 0);
    check(reg_wr_en == 0 && reg_rd_en == 0, "R9 strobes", {reg_wr_en, reg_rd_en}, 0);

    // R2 R4 write burst, R6 mode 0 capture
    write_burst(4'h3, 3, 8'hA5, "R2 write burst");
    // R4 wrap on write
    write_burst(4'hE, 3, 8'h5C, "R4 write wrap");
    // R10 R3 R6 seven-byte read from 0x02
    read_burst(4'h2, 7, "R10 read burst");
    // R4 wrap on read
    read_burst(4'hF, 2, "R4 read wrap");

    // R5 unmarked commands
    rd_before = rd_events;
    cur_req = "R5 ignored write";
    open_xfer();
    xfer_bits(8'h05, 8, rx);
    xfer_bits(8'hFF, 8, rx);
    check(rx == 0, "R5 miso after unmarked cmd", rx, 0);
    xfer_bits(8'h3C, 8, rx);
    close_xfer();
    open_xfer();
    xfer_bits(8'h85, 8, rx);
    xfer_bits(8'h00, 8, rx);
    check(rx == 0, "R5 miso after unmarked read", rx, 0);
    close_xfer();
    check(rd_events == rd_before, "R5 no reads", rd_events, rd_before);

    // R1 clocking with CS low
    cur_req = "R1 cs low";
    for (int i = 0; i < 16; i++) begin
      spi_mosi = i[0];
      repeat (HALF) @(negedge clk);
      spi_sclk = 1;
      check(spi_miso == 0, "R1 miso while deselected", spi_miso, 0);
      repeat (HALF) @(negedge clk);
      spi_sclk = 0;
    end
    repeat (4*HALF) @(negedge clk);
    check(rd_events == rd_before, "R1 no reads", rd_events, rd_before);
    read_burst(4'h0, 1, "R1 reg0 unchanged");

    // R7 partial byte at CS release
    cur_req = "R7 partial";
    open_xfer();
    xfer_bits(8'h17, 8, rx);
    exp_q.push_back({4'h7, 8'h6B});
    ref_mem[7] = 8'h6B;
    xfer_bits(8'h6B, 8, rx);
    xfer_bits(8'hF0, 4, rx);
    close_xfer();
    read_burst(4'h7, 2, "R7 only full byte written");

    // R11 coincident SCLK rise and CS release
    cur_req = "R11 coincident";
    open_xfer();
    xfer_bits(8'h1A, 8, rx);
    xfer_bits(8'hFF, 7, rx);
    spi_mosi = 1;
    repeat (HALF) @(negedge clk);
    spi_cs = 0;
    spi_sclk = 1;
    repeat (HALF) @(negedge clk);
    spi_sclk = 0;
    repeat (4*HALF) @(negedge clk);
    read_burst(4'hA, 1, "R11 reg A unchanged");

    check(exp_q.size() == 0, "R2 all writes seen", exp_q.size(), 0);
    check(overlap_seen == 0, "R8 strobes exclusive", overlap_seen, 0);
    done = 1;
    finish_run();
  end
endmodule